// File: doc/BRIEF.md
# Floating-Point Control Register Interface

This block keeps the control state of a floating-point coprocessor and links it to the integer pipeline. Every cycle the issue stage presents one coprocessor operation code, a control register index, a 32-bit write value and the result of a floating-point compare. In the same cycle the block returns the read data for a control move, the rounding mode that the arithmetic units must use for this operation, the branch decision for a branch on the floating-point condition, and a coprocessor-unusable exception if the status register has coprocessor 1 disabled.

Two control registers are visible. Index 0 is a fixed implementation/revision word that cannot be written. Every other index reaches a single control/status word. Only a fixed set of its bits is implemented, and the rest always read as zero. The low two bits hold the programmed rounding mode and bit 23 holds the compare condition. The convert-to-word operations override the rounding mode for their own cycle only.

The operation code is decoded by a gate stage. Its two outcomes are ACCEPT, where the operation proceeds, and TRAP, where coprocessor 1 is disabled and the operation is turned into IDLE. The decoded operation states are IDLE, CTL_READ, CTL_WRITE, COMPARE, BR_TRUE, BR_FALSE, ARITH, CVT_NEAR, CVT_TRUNC, CVT_CEIL and CVT_FLOOR. State changes take effect at the next rising clock edge. Every output is a combinational function of the present operation and of the state registered before that edge.

Top module: `fpu_ctl_regs`

## Requirements
- R1: `req_op` encodings are: 0 idle, 1 control read, 2 control write, 3 compare, 4 branch-if-true, 5 branch-if-false, 6 arithmetic, 7 convert nearest, 8 convert truncate, 9 convert ceil, 10 convert floor. Codes 11 to 15 behave as idle and never trap. After reset the control/status word is zero, so a read of index 1 returns 0 and `round_mode` is 0.
- R2: A control read of index 0 returns the parameter `IMPL_ID`.
- R3: A control read of any nonzero index returns the control/status word ANDed with 0x0183FFFF. Any operation other than a control read drives `rd_data` to 0.
- R4: A control write to index 0 changes no state and raises no exception.
- R5: A control write to a nonzero index stores `wr_data` AND 0x0183FFFF at the next edge. A read in the same cycle as the write returns the previous value.
- R6: For operations that are not conversions, `round_mode` equals bits [1:0] of the control/status word. The encoding is 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity.
- R7: Convert-nearest drives `round_mode` 0, convert-ceil drives 2 and convert-floor drives 3. The override lasts for that cycle only, and the next operation sees the programmed mode.
- R8: Convert-truncate always drives `round_mode` 1, whatever mode is programmed.
- R9: A compare writes `cmp_true` into bit 23 of the control/status word at the next edge. Branch-if-true drives `branch_taken` with that bit, branch-if-false drives its inverse, and every other operation drives 0.
- R10: When `cu1_enable` is 0, any operation code from 1 to 10 raises `cop_unusable` with `cop_num` = 1. The operation then changes no state, `rd_data` and `branch_taken` are 0, and `round_mode` shows the programmed mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_op | input | 4 | Coprocessor operation code for this cycle |
| ctl_idx | input | 5 | Control register index for reads and writes |
| wr_data | input | 32 | Value to write to the control register |
| cmp_true | input | 1 | Compare result, captured by a compare operation |
| cu1_enable | input | 1 | Coprocessor-1 usable bit from the status register |
| rd_data | output | 32 | Control read data |
| round_mode | output | 2 | Effective rounding mode for this operation |
| branch_taken | output | 1 | Branch decision on the floating-point condition |
| cop_unusable | output | 1 | Coprocessor-unusable exception |
| cop_num | output | 2 | Coprocessor number reported with the exception |

## Verification
The assertions assume that exactly one operation code is presented per cycle and that `req_op`, `ctl_idx`, `wr_data`, `cmp_true` and `cu1_enable` stay steady between clock edges. The stimulus drives all of them on the falling edge. It draws the operation code, index, data and compare result from a seeded generator. `cu1_enable` is cleared on about one cycle in eight, so trapped operations are mixed in among accepted ones. Directed sequences cover writes to index 0, all-ones writes, each rounding override followed by a plain arithmetic operation, and the unused codes 11 to 15.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
    localparam int          XLEN     = 32;
    localparam int          OP_W     = 4;
    localparam int          RM_W     = 2;
    localparam int          COND_BIT = 23;
    localparam logic [31:0] CSR_MASK = 32'h0183_FFFF;

    typedef enum logic [OP_W-1:0] {
        OP_IDLE      = 4'd0,
        OP_CTL_READ  = 4'd1,
        OP_CTL_WRITE = 4'd2,
        OP_COMPARE   = 4'd3,
        OP_BR_TRUE   = 4'd4,
        OP_BR_FALSE  = 4'd5,
        OP_ARITH     = 4'd6,
        OP_CVT_NEAR  = 4'd7,
        OP_CVT_TRUNC = 4'd8,
        OP_CVT_CEIL  = 4'd9,
        OP_CVT_FLOOR = 4'd10
    } fcr_op_e;

    typedef enum logic [RM_W-1:0] {
        RND_NEAREST   = 2'd0,
        RND_ZERO      = 2'd1,
        RND_PLUS_INF  = 2'd2,
        RND_MINUS_INF = 2'd3
    } rnd_e;
endpackage

// File: rtl/fcr_gate.sv
module fcr_gate
    import fcr_pkg::*;
(
    input  logic [OP_W-1:0] op_raw,
    input  logic            cu1_enable,
    output fcr_op_e         op_acc,
    output logic            trap
);
    fcr_op_e decoded;

    always_comb begin
        unique case (op_raw)
            OP_CTL_READ:  decoded = OP_CTL_READ;
            OP_CTL_WRITE: decoded = OP_CTL_WRITE;
            OP_COMPARE:   decoded = OP_COMPARE;
            OP_BR_TRUE:   decoded = OP_BR_TRUE;
            OP_BR_FALSE:  decoded = OP_BR_FALSE;
            OP_ARITH:     decoded = OP_ARITH;
            OP_CVT_NEAR:  decoded = OP_CVT_NEAR;
            OP_CVT_TRUNC: decoded = OP_CVT_TRUNC;
            OP_CVT_CEIL:  decoded = OP_CVT_CEIL;
            OP_CVT_FLOOR: decoded = OP_CVT_FLOOR;
            default:      decoded = OP_IDLE;
        endcase
    end

    always_comb begin
        trap   = (decoded != OP_IDLE) && !cu1_enable;
        op_acc = trap ? OP_IDLE : decoded;
    end
endmodule

// File: rtl/fcr_round_sel.sv
module fcr_round_sel
    import fcr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  fcr_op_e         op_acc,
    input  logic [RM_W-1:0] prog_rm,
    output logic [RM_W-1:0] eff_rm
);
    always_comb begin
        unique case (op_acc)
            OP_CVT_NEAR:  eff_rm = RND_NEAREST;
            OP_CVT_TRUNC: eff_rm = RND_ZERO;
            OP_CVT_CEIL:  eff_rm = RND_PLUS_INF;
            OP_CVT_FLOOR: eff_rm = RND_MINUS_INF;
            default:      eff_rm = prog_rm;
        endcase
    end

    // R8
    trunc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_acc == OP_CVT_TRUNC) |-> (eff_rm == RND_ZERO));
    // R7
    ceil_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_acc == OP_CVT_CEIL) |-> (eff_rm == RND_PLUS_INF));
    // R6
    arith_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_acc == OP_ARITH) |-> (eff_rm == prog_rm));
endmodule

// File: rtl/fcr_store.sv
module fcr_store
    import fcr_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]  wr_data,
    input  logic             cmp_en,
    input  logic             cmp_val,
    output logic [XLEN-1:0]  csr_q
);
    logic csr_write;
    assign csr_write = wr_en && (wr_idx != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csr_q <= '0;
        end else if (csr_write) begin
            csr_q <= wr_data & CSR_MASK;
        end else if (cmp_en) begin
            csr_q[COND_BIT] <= cmp_val;
        end
    end

    // R4
    impl_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == '0 && !cmp_en) |=> $stable(csr_q));
    // R5
    csr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_write |=> (csr_q == ($past(wr_data) & CSR_MASK)));
    // R9
    cond_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && !wr_en) |=> (csr_q[COND_BIT] == $past(cmp_val)));
endmodule

// File: rtl/fpu_ctl_regs.sv
module fpu_ctl_regs
    import fcr_pkg::*;
#(
    parameter int          IDX_W   = 5,
    parameter logic [31:0] IMPL_ID = 32'h0000_0A31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       req_op,
    input  logic [IDX_W-1:0] ctl_idx,
    input  logic [31:0]      wr_data,
    input  logic             cmp_true,
    input  logic             cu1_enable,
    output logic [31:0]      rd_data,
    output logic [1:0]       round_mode,
    output logic             branch_taken,
    output logic             cop_unusable,
    output logic [1:0]       cop_num
);
    localparam logic [1:0] THIS_COP = 2'd1;

    fcr_op_e         op_acc;
    logic            trap;
    logic [XLEN-1:0] csr_q;

    fcr_gate u_gate (
        .op_raw     (req_op),
        .cu1_enable (cu1_enable),
        .op_acc     (op_acc),
        .trap       (trap)
    );

    fcr_store #(.IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (op_acc == OP_CTL_WRITE),
        .wr_idx  (ctl_idx),
        .wr_data (wr_data),
        .cmp_en  (op_acc == OP_COMPARE),
        .cmp_val (cmp_true),
        .csr_q   (csr_q)
    );

    fcr_round_sel u_round (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_acc  (op_acc),
        .prog_rm (csr_q[RM_W-1:0]),
        .eff_rm  (round_mode)
    );

    always_comb begin
        rd_data      = '0;
        branch_taken = 1'b0;
        unique case (op_acc)
            OP_CTL_READ: rd_data = (ctl_idx == '0) ? IMPL_ID : (csr_q & CSR_MASK);
            OP_BR_TRUE:  branch_taken = csr_q[COND_BIT];
            OP_BR_FALSE: branch_taken = !csr_q[COND_BIT];
            default:     ;
        endcase
        cop_unusable = trap;
        cop_num      = trap ? THIS_COP : 2'd0;
    end

    // R10
    trap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cop_unusable |-> (rd_data == '0 && !branch_taken && cop_num == THIS_COP));
    // R10
    trap_nostate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cop_unusable |=> $stable(csr_q));
    // R3
    unused_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data != '0) |-> (req_op == 4'(OP_CTL_READ)));
endmodule

// File: tb/fpu_ctl_regs_bench.sv
`timescale 1ns/1ps
module fpu_ctl_regs_bench;
    localparam logic [31:0] MASK = 32'h0183_FFFF;
    localparam logic [31:0] IMPL = 32'h0000_0A31;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  req_op = '0;
    logic [4:0]  ctl_idx = '0;
    logic [31:0] wr_data = '0;
    logic        cmp_true = 1'b0;
    logic        cu1_enable = 1'b1;
    logic [31:0] rd_data;
    logic [1:0]  round_mode;
    logic        branch_taken;
    logic        cop_unusable;
    logic [1:0]  cop_num;

    int checks = 0;
    int errors = 0;
    logic [31:0] model = '0;

    always #4 clk = ~clk;

    fpu_ctl_regs u_fpu_ctl_regs (
        .clk(clk), .rst_n(rst_n), .req_op(req_op), .ctl_idx(ctl_idx),
        .wr_data(wr_data), .cmp_true(cmp_true), .cu1_enable(cu1_enable),
        .rd_data(rd_data), .round_mode(round_mode), .branch_taken(branch_taken),
        .cop_unusable(cop_unusable), .cop_num(cop_num)
    );

    function automatic string tag_of(input logic [3:0] op, input logic cu1);
        if (!cu1 && op >= 1 && op <= 10) return "R10";
        case (op)
            4'd1:  return (ctl_idx == 0) ? "R2" : "R3";
            4'd2:  return (ctl_idx == 0) ? "R4" : "R5";
            4'd3, 4'd4, 4'd5: return "R9";
            4'd6:  return "R6";
            4'd8:  return "R8";
            4'd7, 4'd9, 4'd10: return "R7";
            default: return "R1";
        endcase
    endfunction

    function automatic logic [31:0] exp_rd(input logic [3:0] op, input logic cu1,
                                           input logic [4:0] idx);
        if (op != 4'd1 || !cu1) return 32'h0;
        return (idx == 0) ? IMPL : (model & MASK);
    endfunction

    function automatic logic [1:0] exp_rm(input logic [3:0] op, input logic cu1);
        if (!cu1) return model[1:0];
        case (op)
            4'd7: return 2'd0;
            4'd8: return 2'd1;
            4'd9: return 2'd2;
            4'd10: return 2'd3;
            default: return model[1:0];
        endcase
    endfunction

    function automatic logic exp_br(input logic [3:0] op, input logic cu1);
        if (!cu1) return 1'b0;
        if (op == 4'd4) return model[23];
        if (op == 4'd5) return !model[23];
        return 1'b0;
    endfunction

    task automatic cmp(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic do_op(input logic [3:0] op, input logic [4:0] idx,
                         input logic [31:0] data, input logic c, input logic cu1);
        logic trapped;
        string t;
        @(negedge clk);
        req_op = op; ctl_idx = idx; wr_data = data; cmp_true = c; cu1_enable = cu1;
        #1;
        t = tag_of(op, cu1);
        trapped = !cu1 && op >= 1 && op <= 10;
        cmp(t, "rd_data", rd_data, exp_rd(op, cu1, idx));
        cmp(t, "round_mode", {30'd0, round_mode}, {30'd0, exp_rm(op, cu1)});
        cmp(t, "branch", {31'd0, branch_taken}, {31'd0, exp_br(op, cu1)});
        cmp(t, "cop_unusable", {31'd0, cop_unusable}, {31'd0, trapped});
        cmp(t, "cop_num", {30'd0, cop_num}, trapped ? 32'd1 : 32'd0);
        if (!trapped) begin
            if (op == 4'd2 && idx != 0) model = data & MASK;
            else if (op == 4'd3) model[23] = c;
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        do_op(4'd1, 5'd1, 32'h0, 1'b0, 1'b1);
        do_op(4'd6, 5'd0, 32'h0, 1'b0, 1'b1);
        // R2 implementation word
        do_op(4'd1, 5'd0, 32'h0, 1'b0, 1'b1);
        // R4 write to index 0 ignored
        do_op(4'd2, 5'd0, 32'hFFFF_FFFF, 1'b0, 1'b1);
        do_op(4'd1, 5'd0, 32'h0, 1'b0, 1'b1);
        do_op(4'd1, 5'd7, 32'h0, 1'b0, 1'b1);
        // R5 R3 all-ones write masked
        do_op(4'd2, 5'd31, 32'hFFFF_FFFF, 1'b0, 1'b1);
        do_op(4'd1, 5'd31, 32'h0, 1'b0, 1'b1);
        // R6 each programmed mode, R7 R8 overrides then plain op
        for (int m = 0; m < 4; m++) begin
            do_op(4'd2, 5'd1, 32'(m), 1'b0, 1'b1);
            do_op(4'd6, 5'd0, 32'h0, 1'b0, 1'b1);
            for (int o = 7; o <= 10; o++) begin
                do_op(4'(o), 5'd0, 32'h0, 1'b0, 1'b1);
                do_op(4'd6, 5'd0, 32'h0, 1'b0, 1'b1);
            end
        end
        // R9 compare then branches
        do_op(4'd3, 5'd0, 32'h0, 1'b1, 1'b1);
        do_op(4'd4, 5'd0, 32'h0, 1'b0, 1'b1);
        do_op(4'd5, 5'd0, 32'h0, 1'b0, 1'b1);
        do_op(4'd3, 5'd0, 32'h0, 1'b0, 1'b1);
        do_op(4'd4, 5'd0, 32'h0, 1'b0, 1'b1);
        do_op(4'd5, 5'd0, 32'h0, 1'b0, 1'b1);
        // R10 trapped write and compare leave state alone
        do_op(4'd2, 5'd1, 32'h0000_0003, 1'b0, 1'b0);
        do_op(4'd3, 5'd0, 32'h0, 1'b1, 1'b0);
        do_op(4'd1, 5'd1, 32'h0, 1'b0, 1'b1);
        // R1 unused codes never trap
        for (int u = 11; u < 16; u++) do_op(4'(u), 5'd0, 32'h0, 1'b0, 1'b0);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            do_op(4'($urandom_range(0, 15)), 5'($urandom_range(0, 3) == 0 ? 0 : $urandom),
                  $urandom, 1'($urandom), ($urandom_range(0, 7) != 0));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule